// File: doc/BRIEF.md
# Clock Source and Standby Controller

This block is the control core of a small clock generator. It chooses which clock feeds the system at run time: the main oscillator, the PLL output (with a times-4 or times-8 multiplier), or a sub-clock taken from either the sub oscillator or the ring oscillator. It also steps the system in and out of four standby modes, and each mode has its own on/off policy for the oscillators. The oscillators, the PLL and the glitch-free clock multiplexer sit outside the block. The controller drives only their enables and selects.

Software programs a clock control word through a write strobe. The word has a source select, a sub-clock route bit, a PLL multiplier bit, a power-save-mode code and an oscillator-disable bit. After reset the controller holds a locked phase. It runs from the main oscillator and refuses every write until the main oscillator reports stable. A refused write changes nothing and raises a sticky error flag. A source switch waits until the requested oscillator reports stable. A standby request parks the clock mux and records the mode. A wake-up event returns the controller to the run state it held before the request.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, lockFlag=1, wrPermit=0, wrErr=0, sleeping=0, and clkMuxSel=3'b001. The stored select, route bit, multiplier bit, mode code and disable bit are all 0.
- R2: A write strobe while lockFlag=1 leaves every stored field unchanged and sets wrErr one cycle later. wrErr then stays 1 until reset.
- R3: While locked, mainStable=1 at a clock edge clears lockFlag and sets wrPermit for the next cycle. The lock never returns without a reset.
- R4: In a run state, clkMuxSel is one-hot. It has bit0 for the main oscillator, bit1 for the PLL and bit2 for the sub-clock. A stored select of 00 picks the main oscillator, 01 picks the sub-clock, and 10 or 11 pick the PLL. The new source appears two clock edges after the write.
- R5: A switch to a source whose stable input is 0 does not happen. It happens on the first edge at which that stable input is 1.
- R6: pllMulX8 follows the stored multiplier bit (1 = times 8). subRouteSosc follows the stored route bit (0 = ring oscillator, 1 = sub oscillator). The stable input used for a sub-clock switch is the one for the routed oscillator.
- R7: A standby request in an unlocked run state sets sleeping. It sets sleepMode to the stored mode code and drives clkMuxSel to 3'b000. While sleeping, wrPermit=0, and writes are refused and set wrErr.
- R8: While sleeping, subOscEn=1 and ringOscEn is the inverse of the disable bit. The mode codes are 00 WATCH, 01 Sub-WATCH, 10 IDLE and 11 STOP. mainOscEn is 0 in STOP and the inverse of the disable bit in the other modes.
- R9: In run and locked states, subOscEn equals the route bit and ringOscEn is its inverse. mainOscEn is 1, except in the sub-clock state with the disable bit set, where it is 0.
- R10: A wake-up while sleeping returns the controller, one edge later, to the run source it used before entry. A wake-up outside standby has no effect.
- R11: A write in the same cycle as a standby request is accepted, but sleepMode takes the mode code stored before that cycle.
- R12: A standby request while locked is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for the clock control word |
| cfgSelIn | input | 2 | Source select write data |
| cfgSubSrcIn | input | 1 | Sub-clock route write data |
| cfgPllX8In | input | 1 | PLL multiplier write data |
| cfgPsmIn | input | 2 | Power-save mode write data |
| cfgOscOffIn | input | 1 | Oscillator-disable write data |
| stbyReq | input | 1 | Standby entry request |
| wakeUp | input | 1 | Wake-up event |
| mainStable | input | 1 | Main oscillator stable |
| pllStable | input | 1 | PLL output stable |
| subStable | input | 1 | Sub oscillator stable |
| ringStable | input | 1 | Ring oscillator stable |
| clkMuxSel | output | 3 | One-hot clock mux select (main, PLL, sub-clock) |
| mainOscEn | output | 1 | Main oscillator enable |
| subOscEn | output | 1 | Sub oscillator enable |
| ringOscEn | output | 1 | Ring oscillator enable |
| pllMulX8 | output | 1 | PLL multiplier select, 1 = times 8 |
| subRouteSosc | output | 1 | Sub-clock route, 1 = sub oscillator |
| wrPermit | output | 1 | Control word writes are accepted |
| lockFlag | output | 1 | Post-reset lock status |
| wrErr | output | 1 | Sticky refused-write flag |
| sleeping | output | 1 | Controller is in standby |
| sleepMode | output | 2 | Mode code latched at standby entry |

## Verification
The run-state sweep writes every combination of select, route, multiplier and disable bit. This separates the two PLL encodings from main and sub-clock, and shows that the disable bit turns off the main oscillator only in the sub-clock state. The standby sweep crosses each return source with all four mode codes and both disable values. Its results tell STOP apart from the other modes, and they show that a wake returns to the saved source, not to a refused write made during sleep. Directed cases hold a stable input low to show that a switch is deferred, and hold the routed sub-clock oscillator unstable while the other one is stable. They also issue writes and standby requests during the lock, a stray wake-up in run, and a write in the same cycle as the standby request.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    ST_LOCK = 3'd0,
    ST_MAIN = 3'd1,
    ST_PLL  = 3'd2,
    ST_SUB  = 3'd3,
    ST_STBY = 3'd4
  } ctl_state_e;

  localparam logic [1:0] PSM_WATCH = 2'b00;
  localparam logic [1:0] PSM_SUBW  = 2'b01;
  localparam logic [1:0] PSM_IDLE  = 2'b10;
  localparam logic [1:0] PSM_STOP  = 2'b11;

  localparam int MUX_W = 3;
  localparam logic [MUX_W-1:0] MUX_MAIN = 3'b001;
  localparam logic [MUX_W-1:0] MUX_PLL  = 3'b010;
  localparam logic [MUX_W-1:0] MUX_SUB  = 3'b100;
  localparam logic [MUX_W-1:0] MUX_NONE = 3'b000;

  typedef struct packed {
    logic [1:0] sel;
    logic       subSrc;
    logic       pllX8;
    logic [1:0] psm;
    logic       oscOff;
  } cfg_word_t;

  typedef struct packed {
    logic wrTake;
    logic wrRefuse;
    logic modeLatch;
  } ctl_strobe_t;

endpackage

// File: rtl/clk_src_regs.sv
module clk_src_regs
  import clk_src_pkg::*;
#(
  parameter logic RST_PLL_X8 = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t strobe,
  input  cfg_word_t   wrData,
  output logic [1:0]  selQ,
  output logic        subSrcQ,
  output logic        pllX8Q,
  output logic        oscOffQ,
  output logic [1:0]  sleepModeQ,
  output logic        wrErrQ
);

  cfg_word_t cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '{sel: 2'b00, subSrc: 1'b0, pllX8: RST_PLL_X8, psm: PSM_WATCH, oscOff: 1'b0};
    end else if (strobe.wrTake) begin
      cfgQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepModeQ <= PSM_WATCH;
    end else if (strobe.modeLatch) begin
      sleepModeQ <= cfgQ.psm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErrQ <= 1'b0;
    end else if (strobe.wrRefuse) begin
      wrErrQ <= 1'b1;
    end
  end

  assign selQ    = cfgQ.sel;
  assign subSrcQ = cfgQ.subSrc;
  assign pllX8Q  = cfgQ.pllX8;
  assign oscOffQ = cfgQ.oscOff;

endmodule

// File: rtl/clk_src_fsm.sv
module clk_src_fsm
  import clk_src_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       sel,
  input  logic             subSrc,
  input  logic             oscOff,
  input  logic [1:0]       sleepMode,
  input  logic             cfgWrEn,
  input  logic             stbyReq,
  input  logic             wakeUp,
  input  logic             mainStable,
  input  logic             pllStable,
  input  logic             subStable,
  input  logic             ringStable,
  output ctl_strobe_t      strobe,
  output logic [MUX_W-1:0] muxSel,
  output logic             mainEn,
  output logic             subEn,
  output logic             ringEn,
  output logic             permit,
  output logic             locked,
  output logic             asleep
);

  ctl_state_e state, stateNext, retState, target;
  logic runState;
  logic targetStable;

  assign runState = (state == ST_MAIN) || (state == ST_PLL) || (state == ST_SUB);
  assign asleep   = (state == ST_STBY);
  assign locked   = (state == ST_LOCK);
  assign permit   = runState;

  always_comb begin
    unique case (sel)
      2'b00:   target = ST_MAIN;
      2'b01:   target = ST_SUB;
      default: target = ST_PLL;
    endcase
  end

  always_comb begin
    unique case (target)
      ST_MAIN: targetStable = mainStable;
      ST_SUB:  targetStable = subSrc ? subStable : ringStable;
      default: targetStable = pllStable;
    endcase
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOCK: if (mainStable) stateNext = ST_MAIN;
      ST_STBY: if (wakeUp) stateNext = retState;
      default: begin
        if (stbyReq) stateNext = ST_STBY;
        else if ((target != state) && targetStable) stateNext = target;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LOCK;
      retState <= ST_MAIN;
    end else begin
      state <= stateNext;
      if (runState && stbyReq) retState <= state;
    end
  end

  always_comb begin
    strobe.wrTake    = cfgWrEn && permit;
    strobe.wrRefuse  = cfgWrEn && !permit;
    strobe.modeLatch = runState && stbyReq;
  end

  always_comb begin
    unique case (state)
      ST_PLL:  muxSel = MUX_PLL;
      ST_SUB:  muxSel = MUX_SUB;
      ST_STBY: muxSel = MUX_NONE;
      default: muxSel = MUX_MAIN;
    endcase
  end

  always_comb begin
    if (asleep) begin
      subEn  = 1'b1;
      ringEn = !oscOff;
      mainEn = (sleepMode == PSM_STOP) ? 1'b0 : !oscOff;
    end else begin
      subEn  = subSrc;
      ringEn = !subSrc;
      mainEn = (state == ST_SUB) ? !oscOff : 1'b1;
    end
  end

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter logic RST_PLL_X8 = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSelIn,
  input  logic       cfgSubSrcIn,
  input  logic       cfgPllX8In,
  input  logic [1:0] cfgPsmIn,
  input  logic       cfgOscOffIn,
  input  logic       stbyReq,
  input  logic       wakeUp,
  input  logic       mainStable,
  input  logic       pllStable,
  input  logic       subStable,
  input  logic       ringStable,
  output logic [2:0] clkMuxSel,
  output logic       mainOscEn,
  output logic       subOscEn,
  output logic       ringOscEn,
  output logic       pllMulX8,
  output logic       subRouteSosc,
  output logic       wrPermit,
  output logic       lockFlag,
  output logic       wrErr,
  output logic       sleeping,
  output logic [1:0] sleepMode
);

  ctl_strobe_t strobe;
  cfg_word_t   wrData;
  logic [1:0]  selQ;
  logic        oscOffQ;

  assign wrData = '{sel: cfgSelIn, subSrc: cfgSubSrcIn, pllX8: cfgPllX8In,
                    psm: cfgPsmIn, oscOff: cfgOscOffIn};

  clk_src_regs #(.RST_PLL_X8(RST_PLL_X8)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .selQ       (selQ),
    .subSrcQ    (subRouteSosc),
    .pllX8Q     (pllMulX8),
    .oscOffQ    (oscOffQ),
    .sleepModeQ (sleepMode),
    .wrErrQ     (wrErr)
  );

  clk_src_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .sel        (selQ),
    .subSrc     (subRouteSosc),
    .oscOff     (oscOffQ),
    .sleepMode  (sleepMode),
    .cfgWrEn    (cfgWrEn),
    .stbyReq    (stbyReq),
    .wakeUp     (wakeUp),
    .mainStable (mainStable),
    .pllStable  (pllStable),
    .subStable  (subStable),
    .ringStable (ringStable),
    .strobe     (strobe),
    .muxSel     (clkMuxSel),
    .mainEn     (mainOscEn),
    .subEn      (subOscEn),
    .ringEn     (ringOscEn),
    .permit     (wrPermit),
    .locked     (lockFlag),
    .asleep     (sleeping)
  );

endmodule

// File: rtl/clk_src_chk.sv
module clk_src_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic       stbyReq,
  input logic       wakeUp,
  input logic       mainStable,
  input logic [2:0] clkMuxSel,
  input logic       mainOscEn,
  input logic       subOscEn,
  input logic       wrPermit,
  input logic       lockFlag,
  input logic       wrErr,
  input logic       sleeping,
  input logic [1:0] sleepMode
);

  p_locked_reject_r2: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && cfgWrEn |=> wrErr);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |=> wrErr);

  p_unlock_r3: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && mainStable |=> !lockFlag && wrPermit);

  p_no_relock_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lockFlag |=> !lockFlag);

  p_run_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sleeping |-> $countones(clkMuxSel) == 1);

  p_sleep_mux_r7: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> clkMuxSel == 3'b000 && !wrPermit);

  p_stop_main_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleeping && sleepMode == 2'b11 |-> !mainOscEn);

  p_sleep_sub_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> subOscEn);

  p_stray_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    !sleeping && wakeUp && !stbyReq |=> !sleeping);

  p_locked_stby_r12: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && stbyReq |=> !sleeping);

endmodule

bind clk_src_ctrl clk_src_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .stbyReq    (stbyReq),
  .wakeUp     (wakeUp),
  .mainStable (mainStable),
  .clkMuxSel  (clkMuxSel),
  .mainOscEn  (mainOscEn),
  .subOscEn   (subOscEn),
  .wrPermit   (wrPermit),
  .lockFlag   (lockFlag),
  .wrErr      (wrErr),
  .sleeping   (sleeping),
  .sleepMode  (sleepMode)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgSubSrcIn = 0, cfgPllX8In = 0, cfgOscOffIn = 0;
  logic [1:0] cfgSelIn = 0, cfgPsmIn = 0;
  logic stbyReq = 0, wakeUp = 0;
  logic mainStable = 0, pllStable = 0, subStable = 0, ringStable = 0;
  logic [2:0] clkMuxSel;
  logic mainOscEn, subOscEn, ringOscEn, pllMulX8, subRouteSosc;
  logic wrPermit, lockFlag, wrErr, sleeping;
  logic [1:0] sleepMode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  clk_src_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSelIn(cfgSelIn),
    .cfgSubSrcIn(cfgSubSrcIn), .cfgPllX8In(cfgPllX8In), .cfgPsmIn(cfgPsmIn),
    .cfgOscOffIn(cfgOscOffIn), .stbyReq(stbyReq), .wakeUp(wakeUp),
    .mainStable(mainStable), .pllStable(pllStable), .subStable(subStable),
    .ringStable(ringStable), .clkMuxSel(clkMuxSel), .mainOscEn(mainOscEn),
    .subOscEn(subOscEn), .ringOscEn(ringOscEn), .pllMulX8(pllMulX8),
    .subRouteSosc(subRouteSosc), .wrPermit(wrPermit), .lockFlag(lockFlag),
    .wrErr(wrErr), .sleeping(sleeping), .sleepMode(sleepMode)
  );

  task automatic ck(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic sub, logic x8, logic [1:0] p, logic off);
    cfgSelIn = s; cfgSubSrcIn = sub; cfgPllX8In = x8; cfgPsmIn = p; cfgOscOffIn = off;
    cfgWrEn = 1'b1;
    step();
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [2:0] muxFor(logic [1:0] s);
    return (s == 2'b00) ? 3'b001 : (s == 2'b01) ? 3'b100 : 3'b010;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    // R1 reset state
    ck("R1 lockFlag", lockFlag, 1);
    ck("R1 wrPermit", wrPermit, 0);
    ck("R1 wrErr", wrErr, 0);
    ck("R1 sleeping", sleeping, 0);
    ck("R1 mux", clkMuxSel, 3'b001);
    ck("R1 pllMulX8", pllMulX8, 0);
    ck("R1 subRoute", subRouteSosc, 0);
    ck("R9 reset enables", {mainOscEn, subOscEn, ringOscEn}, 3'b101);

    // R12 standby request while locked
    stbyReq = 1'b1; step(); stbyReq = 1'b0;
    ck("R12 locked standby ignored", sleeping, 0);
    ck("R12 mux stays main", clkMuxSel, 3'b001);

    // R2 refused write while locked
    pllStable = 1'b1;
    wr(2'b10, 1'b1, 1'b1, 2'b11, 1'b1);
    ck("R2 wrErr set", wrErr, 1);
    ck("R2 multiplier unchanged", pllMulX8, 0);
    ck("R2 route unchanged", subRouteSosc, 0);

    // R3 unlock
    mainStable = 1'b1;
    step();
    ck("R3 lock cleared", lockFlag, 0);
    ck("R3 permit", wrPermit, 1);
    step(2);
    ck("R2 select unchanged after unlock", clkMuxSel, 3'b001);
    ck("R2 wrErr sticky", wrErr, 1);

    subStable = 1'b1; ringStable = 1'b1;
    // R4 R6 R9 run sweep
    for (int s = 0; s < 4; s++)
      for (int sub = 0; sub < 2; sub++)
        for (int x8 = 0; x8 < 2; x8++)
          for (int off = 0; off < 2; off++) begin
            wr(s[1:0], sub[0], x8[0], 2'b00, off[0]);
            step();
            ck("R4 mux", clkMuxSel, muxFor(s[1:0]));
            ck("R6 multiplier", pllMulX8, x8[0]);
            ck("R6 route", subRouteSosc, sub[0]);
            ck("R9 sub enable", subOscEn, sub[0]);
            ck("R9 ring enable", ringOscEn, !sub[0]);
            ck("R9 main enable", mainOscEn, (s == 1 && off == 1) ? 1'b0 : 1'b1);
            ck("R3 stays unlocked", lockFlag, 0);
          end

    // R5 deferred switch
    wr(2'b00, 1'b0, 1'b0, 2'b00, 1'b0);
    step();
    pllStable = 1'b0;
    wr(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    step(3);
    ck("R5 switch held", clkMuxSel, 3'b001);
    pllStable = 1'b1;
    step();
    ck("R5 switch after stable", clkMuxSel, 3'b010);

    // R6 sub-clock stability taken from routed oscillator
    subStable = 1'b0;
    wr(2'b01, 1'b1, 1'b0, 2'b00, 1'b0);
    step(3);
    ck("R6 routed osc unstable", clkMuxSel, 3'b010);
    subStable = 1'b1;
    step();
    ck("R6 routed osc stable", clkMuxSel, 3'b100);

    // R7 R8 R10 standby sweep
    for (int r = 0; r < 3; r++)
      for (int p = 0; p < 4; p++)
        for (int off = 0; off < 2; off++) begin
          wr(r[1:0], 1'b0, 1'b0, p[1:0], off[0]);
          step();
          stbyReq = 1'b1; step(); stbyReq = 1'b0;
          ck("R7 sleeping", sleeping, 1);
          ck("R7 mode latched", sleepMode, p[1:0]);
          ck("R7 mux parked", clkMuxSel, 3'b000);
          ck("R7 permit low", wrPermit, 0);
          ck("R8 sub on", subOscEn, 1);
          ck("R8 ring", ringOscEn, !off[0]);
          ck("R8 main", mainOscEn, (p == 3) ? 1'b0 : !off[0]);
          wr(2'(r + 1), 1'b1, 1'b1, 2'(p + 1), !off[0]);
          ck("R7 write refused while asleep", {pllMulX8, subRouteSosc}, 2'b00);
          wakeUp = 1'b1; step(); wakeUp = 1'b0;
          ck("R10 awake", sleeping, 0);
          ck("R10 return source", clkMuxSel, muxFor(r[1:0]));
          step(2);
          ck("R7 select unchanged by refused write", clkMuxSel, muxFor(r[1:0]));
        end

    // R10 stray wake-up
    wakeUp = 1'b1; step(); wakeUp = 1'b0;
    ck("R10 stray wake ignored", sleeping, 0);
    ck("R10 stray wake mux", clkMuxSel, 3'b010);

    // R11 same-cycle write and standby
    wr(2'b00, 1'b0, 1'b0, 2'b01, 1'b0);
    step();
    cfgSelIn = 2'b00; cfgSubSrcIn = 1'b1; cfgPllX8In = 1'b1; cfgPsmIn = 2'b11; cfgOscOffIn = 1'b0;
    cfgWrEn = 1'b1; stbyReq = 1'b1;
    step();
    cfgWrEn = 1'b0; stbyReq = 1'b0;
    ck("R11 old mode used", sleepMode, 2'b01);
    ck("R11 main kept on", mainOscEn, 1);
    ck("R11 write accepted", pllMulX8, 1);
    wakeUp = 1'b1; step(); wakeUp = 1'b0;
    ck("R11 return main", clkMuxSel, 3'b001);

    // R7 fresh reset: refused write in standby raises wrErr
    rstN = 1'b0; step(2); rstN = 1'b1; step();
    ck("R1 wrErr cleared by reset", wrErr, 0);
    step();
    ck("R3 unlocked again", lockFlag, 0);
    stbyReq = 1'b1; step(); stbyReq = 1'b0;
    ck("R7 asleep", sleeping, 1);
    ck("R7 wrErr before write", wrErr, 0);
    wr(2'b10, 1'b0, 1'b0, 2'b00, 1'b0);
    ck("R7 wrErr after refused write", wrErr, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule